// File: doc/BRIEF.md
# Stereo Serial Audio Port with Sample Queues

This block connects a processor bus to a stereo audio codec over a three-wire serial audio link. It drives the bit clock and the left/right word clock, shifts out playback samples and shifts in capture samples. Software writes one 32-bit stereo word per access into a small playback queue and reads captured words from a capture queue. Each word carries the left sample in bits [31:16] and the right sample in bits [15:0].

Each queue has a fill-level alert with its own threshold. The playback alert fires when there is more free space than its threshold. The capture alert fires when there is less free space than its threshold. Either alert can drive the single interrupt line. Sticky error flags record lost or invented samples, and one register offset reads them and clears them by writing ones. A ten-bit divider sets the frame rate. Two control bits flush both queues and drive the codec reset pin.

Top module: `aud_i2s_ctrl`

## Requirements
- R1: After reset the control register reads 0, the divider reads 0x080, the status register reads 0x15, the error register reads 0, and sclk_o, lrck_o, sdout_o, irq_o and codec_rst_o are low.
- R2: Control register (word index 0) fields: bit 0 playback enable, bit 1 playback interrupt enable, bit 2 capture enable, bit 3 capture interrupt enable, bits [10:8] playback threshold, bits [14:12] capture threshold, bit 16 queue flush, bit 17 codec reset. Every other bit reads as 0, and codec_rst_o follows bit 17.
- R3: Status register (word index 1) fields: bit 0 playback alert, bit 1 capture alert, bit 2 playback queue empty, bit 3 playback queue full, bit 4 capture queue empty, bit 5 capture queue full. Each queue holds DEPTH (4) words.
- R4: The playback alert is 1 exactly when (DEPTH minus playback fill) is greater than the playback threshold.
- R5: The capture alert is 1 exactly when (DEPTH minus capture fill) is less than the capture threshold.
- R6: irq_o is high when the playback alert and its enable are both set, or when the capture alert and its enable are both set.
- R7: A write to the playback port (word index 4) while the playback queue is full discards the word and sets error bit 0.
- R8: When a frame starts with playback enabled and the playback queue empty, the frame sends all zeros and sets error bit 0.
- R9: A frame that completes with capture enabled and the capture queue full is discarded and sets error bit 1. A read of the capture port (word index 5) while the capture queue is empty returns 0 and sets error bit 1.
- R10: Error register (word index 2): bit 0 is the playback error and bit 1 is the capture error. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and otherwise a flag stays set.
- R11: The divider register (word index 3) keeps 10 bits. sclk_o toggles every max(divider/32, 1) core cycles, and lrck_o toggles after 32 sclk half-periods, so each lrck_o level lasts divider cycles when the divider is a multiple of 32.
- R12: Each frame pops one playback word at its start. During the frame, lrck_o is low for the 16 left bits and high for the 16 right bits, MSB first. sdout_o changes on sclk_o falling edges and sdin_i is sampled on sclk_o rising edges. lrck_o changes only together with a falling sclk_o. The captured word is pushed with the same packing when the right half ends.
- R13: While the flush bit is set, both queues are held empty and writes to the playback port are lost without an error.
- R14: With both enables clear, sclk_o and lrck_o are held low and the next frame starts from the left half. With playback disabled, sdout_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the capture queue at index 5) |
| bus_idx | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the index |
| sdin_i | input | 1 | Serial capture data from the codec |
| sclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Word clock, low = left channel |
| sdout_o | output | 1 | Serial playback data |
| codec_rst_o | output | 1 | Codec reset, follows control bit 17 |
| irq_o | output | 1 | Combined queue-level interrupt |

## Verification
The serial output is looped back to the serial input, and four distinct stereo words with asymmetric halves are sent. A swapped channel, a reversed bit order or a shift by one bit would each change what the capture queue returns. The bench keeps running the link after the playback queue drains, so the zero frames and the capture overflow show up in the error flags. Capture-only runs with a constant high input and a doubled divider measure the word-clock half-period and check that playback stays silent. Threshold values are stepped across their edges (0 and 3 for playback, 1 and 4 for capture) to show the difference between a strict comparison and an inclusive one.

// File: rtl/aud_pkg.sv
package aud_pkg;

   // register word indices
   localparam logic [2:0] IDX_CTRL = 3'd0;
   localparam logic [2:0] IDX_STAT = 3'd1;
   localparam logic [2:0] IDX_ERR  = 3'd2;
   localparam logic [2:0] IDX_DIV  = 3'd3;
   localparam logic [2:0] IDX_TXP  = 3'd4;
   localparam logic [2:0] IDX_RXP  = 3'd5;

   // control field positions
   localparam int CB_TXEN  = 0;
   localparam int CB_TXIE  = 1;
   localparam int CB_RXEN  = 2;
   localparam int CB_RXIE  = 3;
   localparam int CB_TXWL  = 8;
   localparam int CB_RXWL  = 12;
   localparam int CB_FLUSH = 16;
   localparam int CB_CODEC = 17;
   localparam int WL_W     = 3;

   typedef struct packed {
      logic            codec_rst;
      logic            flush;
      logic [WL_W-1:0] rx_wl;
      logic [WL_W-1:0] tx_wl;
      logic            rx_ie;
      logic            rx_en;
      logic            tx_ie;
      logic            tx_en;
   } ctl_t;

endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("aud_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          push_ok, pop_ok;
   logic [W-1:0]  ent [DEPTH];

   assign full    = (cnt_q == CNT_FULL);
   assign empty   = (cnt_q == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign count   = cnt_q;
   assign dout    = ent[rd_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (push_ok && wr_q == AW'(i)) q <= din;
      end
      assign ent[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_q + AW'(1);
         if (pop_ok)  rd_q <= rd_q + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/aud_regs.sv
module aud_regs
   import aud_pkg::*;
#(
   parameter int W       = 32,
   parameter int DEPTH   = 4,
   parameter int CW      = 3,
   parameter int DIV_W   = 10,
   parameter int DIV_RST = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [2:0]       bus_idx,
   input  logic [W-1:0]     bus_wdata,
   output logic [W-1:0]     bus_rdata,
   input  logic [CW-1:0]    tx_count,
   input  logic             tx_full,
   input  logic             tx_empty,
   input  logic [CW-1:0]    rx_count,
   input  logic             rx_full,
   input  logic             rx_empty,
   input  logic [W-1:0]     rx_head,
   input  logic             tx_udf,
   input  logic             rx_ovf,
   output ctl_t             ctl,
   output logic [DIV_W-1:0] divide,
   output logic             tx_push,
   output logic             rx_pop,
   output logic [1:0]       err,
   output logic             irq
);

   generate
      if (W < CB_CODEC + 1) begin : g_bad_w
         $error("aud_regs: data width too small for the control fields");
      end
      if (DIV_W > W) begin : g_bad_div
         $error("aud_regs: divider wider than the data bus");
      end
   endgenerate

   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   logic [CW-1:0] tx_free, rx_free;
   logic          tx_alert, rx_alert;
   logic          wr_txp, rd_rxp, tx_ovf, rx_udf, wr_err;
   logic [5:0]    stat;
   logic [W-1:0]  ctl_rd;

   always_comb begin
      tx_free  = CNT_FULL - tx_count;
      rx_free  = CNT_FULL - rx_count;
      tx_alert = 32'(tx_free) > 32'(ctl.tx_wl);
      rx_alert = 32'(rx_free) < 32'(ctl.rx_wl);
      stat     = {rx_full, rx_empty, tx_full, tx_empty, rx_alert, tx_alert};
      irq      = (tx_alert && ctl.tx_ie) || (rx_alert && ctl.rx_ie);
   end

   assign wr_txp  = bus_wr && (bus_idx == IDX_TXP);
   assign rd_rxp  = bus_rd && (bus_idx == IDX_RXP);
   assign wr_err  = bus_wr && (bus_idx == IDX_ERR);
   assign tx_push = wr_txp && !tx_full;
   assign tx_ovf  = wr_txp && tx_full;
   assign rx_pop  = rd_rxp && !rx_empty;
   assign rx_udf  = rd_rxp && rx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '0;
         divide <= DIV_W'(DIV_RST);
         err    <= '0;
      end else begin
         if (bus_wr && bus_idx == IDX_CTRL) begin
            ctl.tx_en     <= bus_wdata[CB_TXEN];
            ctl.tx_ie     <= bus_wdata[CB_TXIE];
            ctl.rx_en     <= bus_wdata[CB_RXEN];
            ctl.rx_ie     <= bus_wdata[CB_RXIE];
            ctl.tx_wl     <= bus_wdata[CB_TXWL +: WL_W];
            ctl.rx_wl     <= bus_wdata[CB_RXWL +: WL_W];
            ctl.flush     <= bus_wdata[CB_FLUSH];
            ctl.codec_rst <= bus_wdata[CB_CODEC];
         end
         if (bus_wr && bus_idx == IDX_DIV) divide <= bus_wdata[DIV_W-1:0];
         // a new event in the same cycle as a clear keeps the flag set
         if (tx_ovf || tx_udf)              err[0] <= 1'b1;
         else if (wr_err && bus_wdata[0])   err[0] <= 1'b0;
         if (rx_ovf || rx_udf)              err[1] <= 1'b1;
         else if (wr_err && bus_wdata[1])   err[1] <= 1'b0;
      end
   end

   always_comb begin
      ctl_rd                      = '0;
      ctl_rd[CB_TXEN]             = ctl.tx_en;
      ctl_rd[CB_TXIE]             = ctl.tx_ie;
      ctl_rd[CB_RXEN]             = ctl.rx_en;
      ctl_rd[CB_RXIE]             = ctl.rx_ie;
      ctl_rd[CB_TXWL +: WL_W]     = ctl.tx_wl;
      ctl_rd[CB_RXWL +: WL_W]     = ctl.rx_wl;
      ctl_rd[CB_FLUSH]            = ctl.flush;
      ctl_rd[CB_CODEC]            = ctl.codec_rst;
      case (bus_idx)
         IDX_CTRL: bus_rdata = ctl_rd;
         IDX_STAT: bus_rdata = W'(stat);
         IDX_ERR:  bus_rdata = W'(err);
         IDX_DIV:  bus_rdata = W'(divide);
         IDX_RXP:  bus_rdata = rx_empty ? '0 : rx_head;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/aud_serdes.sv
module aud_serdes #(
   parameter int CH_W  = 16,
   parameter int DIV_W = 10,
   localparam int W    = 2 * CH_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             rx_en,
   input  logic [DIV_W-1:0] divide,
   input  logic             tx_empty,
   input  logic [W-1:0]     tx_head,
   input  logic             rx_full,
   input  logic             sdin,
   output logic             tx_pop,
   output logic             tx_udf,
   output logic             rx_push,
   output logic             rx_ovf,
   output logic [W-1:0]     rx_word,
   output logic             sclk,
   output logic             lrck,
   output logic             sdout
);

   // sclk half-periods per word-clock level
   localparam int PH_N = 2 * CH_W;
   localparam int PH_W = $clog2(PH_N);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

   generate
      if ((CH_W & (CH_W - 1)) != 0 || CH_W < 2) begin : g_bad_ch
         $error("aud_serdes: CH_W must be a power of two");
      end
      if (DIV_W <= PH_W) begin : g_bad_div
         $error("aud_serdes: divider too narrow for the channel width");
      end
   endgenerate

   logic             run, run_q, tick, ph_last, frame_end, load;
   logic [DIV_W-1:0] half, step, sub_q;
   logic [PH_W-1:0]  ph_q;
   logic             lr_q;
   logic [W-1:0]     tx_sh_q, rx_sh_q;

   assign run       = tx_en | rx_en;
   assign half      = divide >> PH_W;
   assign step      = (half == '0) ? '0 : half - DIV_W'(1);
   assign tick      = run_q && (sub_q >= step);
   assign ph_last   = (ph_q == PH_LAST);
   assign frame_end = tick && ph_last && lr_q;
   assign load      = run && (!run_q || frame_end);

   assign tx_pop  = load && tx_en && !tx_empty;
   assign tx_udf  = load && tx_en && tx_empty;
   assign rx_push = frame_end && rx_en && !rx_full;
   assign rx_ovf  = frame_end && rx_en && rx_full;
   assign rx_word = rx_sh_q;

   assign sclk  = ph_q[0];
   assign lrck  = lr_q;
   assign sdout = tx_en & tx_sh_q[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         sub_q   <= '0;
         ph_q    <= '0;
         lr_q    <= 1'b0;
         tx_sh_q <= '0;
      end else if (!run) begin
         run_q   <= 1'b0;
         sub_q   <= '0;
         ph_q    <= '0;
         lr_q    <= 1'b0;
         tx_sh_q <= '0;
      end else begin
         run_q <= 1'b1;
         if (run_q) begin
            if (tick) begin
               sub_q <= '0;
               ph_q  <= ph_q + PH_W'(1);
               if (ph_last) lr_q <= ~lr_q;
            end else begin
               sub_q <= sub_q + DIV_W'(1);
            end
         end
         if (load)                tx_sh_q <= tx_pop ? tx_head : '0;
         else if (tick && ph_q[0]) tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
      end
   end

   // capture shifter samples on the rising bit clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rx_sh_q <= '0;
      else if (tick && !ph_q[0])  rx_sh_q <= {rx_sh_q[W-2:0], sdin};
   end

endmodule

// File: rtl/aud_i2s_ctrl.sv
module aud_i2s_ctrl
   import aud_pkg::*;
#(
   parameter int CH_W    = 16,
   parameter int DEPTH   = 4,
   parameter int DIV_W   = 10,
   parameter int DIV_RST = 128,
   localparam int W      = 2 * CH_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_wr,
   input  logic         bus_rd,
   input  logic [2:0]   bus_idx,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic         sdin_i,
   output logic         sclk_o,
   output logic         lrck_o,
   output logic         sdout_o,
   output logic         codec_rst_o,
   output logic         irq_o
);

   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DIV_RST >= (1 << DIV_W)) begin : g_bad_rst
         $error("aud_i2s_ctrl: divider reset value does not fit");
      end
   endgenerate

   ctl_t             ctl;
   logic [DIV_W-1:0] divide;
   logic [1:0]       err_flags;
   logic [CW-1:0]    tx_cnt, rx_cnt;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic             tx_push, tx_pop, rx_push, rx_pop, tx_udf, rx_ovf;
   logic [W-1:0]     tx_head, rx_head, rx_word;

   aud_regs #(.W(W), .DEPTH(DEPTH), .CW(CW), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_idx(bus_idx),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_count(tx_cnt), .tx_full(tx_full), .tx_empty(tx_empty),
      .rx_count(rx_cnt), .rx_full(rx_full), .rx_empty(rx_empty), .rx_head(rx_head),
      .tx_udf(tx_udf), .rx_ovf(rx_ovf), .ctl(ctl), .divide(divide),
      .tx_push(tx_push), .rx_pop(rx_pop), .err(err_flags), .irq(irq_o)
   );

   aud_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(ctl.flush), .push(tx_push), .din(bus_wdata),
      .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   aud_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(ctl.flush), .push(rx_push), .din(rx_word),
      .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   aud_serdes #(.CH_W(CH_W), .DIV_W(DIV_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .tx_en(ctl.tx_en), .rx_en(ctl.rx_en), .divide(divide),
      .tx_empty(tx_empty), .tx_head(tx_head), .rx_full(rx_full), .sdin(sdin_i),
      .tx_pop(tx_pop), .tx_udf(tx_udf), .rx_push(rx_push), .rx_ovf(rx_ovf),
      .rx_word(rx_word), .sclk(sclk_o), .lrck(lrck_o), .sdout(sdout_o)
   );

   assign codec_rst_o = ctl.codec_rst;

endmodule

// File: rtl/aud_i2s_ctrl_chk.sv
module aud_i2s_ctrl_chk
   import aud_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CW    = 3,
   parameter int W     = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [2:0]    bus_idx,
   input logic [W-1:0]  bus_wdata,
   input ctl_t          ctl,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt,
   input logic          tx_full,
   input logic [1:0]    err_flags,
   input logic          irq_o,
   input logic          sclk_o,
   input logic          lrck_o
);

   logic run;
   assign run = ctl.tx_en | ctl.rx_en;

   // R13
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.flush |=> (tx_cnt == '0 && rx_cnt == '0));

   // R14
   idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!sclk_o && !lrck_o));

   // R7
   tx_ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_idx == IDX_TXP && tx_full) |=> err_flags[0]);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flags[1] && !(bus_wr && bus_idx == IDX_ERR && bus_wdata[1])) |=> err_flags[1]);

   // R12
   lrck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && lrck_o != $past(lrck_o)) |-> $fell(sclk_o));

   // R6
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ctl.rx_ie) |-> (ctl.tx_ie && (DEPTH - int'(tx_cnt)) > int'(ctl.tx_wl)));

endmodule

bind aud_i2s_ctrl aud_i2s_ctrl_chk #(.DEPTH(DEPTH), .CW(CW), .W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
   .ctl(ctl), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_full(tx_full),
   .err_flags(err_flags), .irq_o(irq_o), .sclk_o(sclk_o), .lrck_o(lrck_o)
);

// File: tb/aud_i2s_ctrl_test.sv
`timescale 1ns/1ps
module aud_i2s_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_idx = 3'd0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        sdin_i, sclk_o, lrck_o, sdout_o, codec_rst_o, irq_o;
   logic        loop_on = 1'b1, sdin_val = 1'b0;

   always #5 clk = ~clk;
   assign sdin_i = loop_on ? sdout_o : sdin_val;

   aud_i2s_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_idx(bus_idx),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sdin_i(sdin_i), .sclk_o(sclk_o),
      .lrck_o(lrck_o), .sdout_o(sdout_o), .codec_rst_o(codec_rst_o), .irq_o(irq_o)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [31:0] tx_q[$], rx_q[$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] idx, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] idx, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_idx = idx;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [2:0] idx, logic [31:0] exp);
      logic [31:0] d;
      rd(idx, d);
      chk(req, d, exp);
   endtask

   // driver: words that should reach the link are queued for both monitors
   task automatic send(logic [31:0] d, bit expect_out);
      wr(3'd4, d);
      if (expect_out) begin
         tx_q.push_back(d);
         rx_q.push_back(d);
      end
   endtask

   // serial monitor
   bit          mon_on = 1'b0;
   int          bitcnt = 0;
   logic        sclk_prev = 1'b0;
   logic [31:0] word = '0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (sclk_o && !sclk_prev) begin
            word = {word[30:0], sdout_o};
            if (lrck_o !== (bitcnt >= 16)) chk("R12 lrck level", {31'b0, lrck_o}, {31'b0, bitcnt >= 16});
            bitcnt++;
            if (bitcnt == 32) begin
               if (tx_q.size() > 0) chk("R12 frame", word, tx_q.pop_front());
               else                 chk("R8 underrun zeros", word, 32'h0);
               bitcnt = 0;
            end
         end
      end else begin
         bitcnt = 0;
      end
      sclk_prev = sclk_o;
   end

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk("R1 ctrl", 3'd0, 32'h0);
      rd_chk("R1 divider", 3'd3, 32'h80);
      rd_chk("R1 status", 3'd1, 32'h15);
      rd_chk("R1 error", 3'd2, 32'h0);
      chk("R1 pins", {27'b0, sclk_o, lrck_o, sdout_o, irq_o, codec_rst_o}, 32'h0);

      // R11 divider width
      wr(3'd3, 32'hFFFF_FFFF);
      rd_chk("R11 divider 10 bits", 3'd3, 32'h3FF);
      wr(3'd3, 32'd32);

      // fill playback queue, then overflow (R7)
      send(32'h1234_ABCD, 1);
      send(32'h8001_7FFE, 1);
      send(32'hC3A5_0F96, 1);
      send(32'h0102_F0E0, 1);
      rd_chk("R3 full status", 3'd1, 32'h18);
      send(32'hDEAD_BEEF, 0);
      rd_chk("R7 overflow flag", 3'd2, 32'h1);
      wr(3'd2, 32'h2);
      rd_chk("R10 write 0 keeps flag", 3'd2, 32'h1);
      wr(3'd2, 32'h1);
      rd_chk("R10 write 1 clears", 3'd2, 32'h0);

      // loopback run: playback + capture + playback irq enable
      mon_on = 1'b1;
      wr(3'd0, 32'h7);
      repeat (6 * 64 + 20) @(negedge clk);
      wr(3'd0, 32'h2);
      mon_on = 1'b0;
      chk("R12 all words sent", tx_q.size(), 0);
      rd_chk("R8 R9 error flags", 3'd2, 32'h3);
      rd_chk("R3 status after run", 3'd1, 32'h25);
      chk("R6 playback irq", {31'b0, irq_o}, 32'h1);
      chk("R14 idle clocks", {30'b0, sclk_o, lrck_o}, 32'h0);

      // capture threshold edges (R5)
      wr(3'd0, 32'h4008);
      rd_chk("R5 threshold 4 full", 3'd1, 32'h27);
      chk("R6 capture irq", {31'b0, irq_o}, 32'h1);
      wr(3'd0, 32'h1008);
      chk("R5 threshold 1 full", {31'b0, irq_o}, 32'h1);
      rd_chk("R12 capture word 0", 3'd5, rx_q.pop_front());
      chk("R5 threshold 1 one free", {31'b0, irq_o}, 32'h0);
      for (int i = 0; i < 3; i++) rd_chk("R12 capture word", 3'd5, rx_q.pop_front());
      wr(3'd2, 32'h3);
      rd_chk("R9 read empty returns 0", 3'd5, 32'h0);
      rd_chk("R9 read empty flag", 3'd2, 32'h2);
      wr(3'd2, 32'h3);

      // playback threshold edges (R4)
      wr(3'd0, 32'h300);
      rd_chk("R4 threshold 3 empty", 3'd1, 32'h15);
      send(32'h5555_AAAA, 0);
      rd_chk("R4 threshold 3 one used", 3'd1, 32'h10);

      // flush (R13) and codec reset (R2)
      wr(3'd0, 32'h1_0000);
      rd_chk("R13 flushed status", 3'd1, 32'h15);
      send(32'h7777_8888, 0);
      rd_chk("R13 write during flush", 3'd1, 32'h15);
      rd_chk("R13 no error", 3'd2, 32'h0);
      wr(3'd0, 32'h2_0000);
      chk("R2 codec pin", {31'b0, codec_rst_o}, 32'h1);
      wr(3'd0, 32'hFFFF_FFFF);
      rd_chk("R2 ctrl readback", 3'd0, 32'h3_770F);
      wr(3'd0, 32'h0);
      chk("R2 codec pin low", {31'b0, codec_rst_o}, 32'h0);
      wr(3'd2, 32'h3);

      // capture-only with constant high input and doubled divider (R11, R14)
      loop_on = 1'b0; sdin_val = 1'b1;
      wr(3'd3, 32'd64);
      wr(3'd0, 32'h4);
      while (!lrck_o) begin
         @(negedge clk);
         if (sdout_o) chk("R14 silent playback", 32'h1, 32'h0);
      end
      hi = 0;
      while (lrck_o) begin
         @(negedge clk);
         hi++;
      end
      chk("R11 lrck half-period", hi, 64);
      repeat (4) @(negedge clk);
      wr(3'd0, 32'h0);
      rd_chk("R12 captured ones", 3'd5, 32'hFFFF_FFFF);
      rd_chk("R14 no playback error", 3'd2, 32'h0);
      chk("R14 clocks low", {30'b0, sclk_o, lrck_o}, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule